// File: doc/BRIEF.md
# Requester ID to MSI Sideband Mapper

This block sits in a PCIe root complex beside the path that carries message-signalled interrupt writes. Every such write carries a 16-bit Requester ID. The bus number is in bits [15:8], the device number in bits [7:3] and the function number in bits [2:0]. The block turns that ID into sideband data for each of a small, fixed set of MSI controller targets. For each target it gives one valid flag and one 16-bit sideband value. A target whose flag is low cannot be addressed by that ID.

The translation comes from a table of eight range entries and one global mask, both written by software. Each entry holds:
- an enable bit,
- a 16-bit ID base,
- a 17-bit length,
- a target index,
- a 16-bit output base.

For a lookup, the block first ANDs the ID with the mask. It then checks the masked ID against each enabled entry's half-open window. A hit produces the masked ID, minus the ID base, plus the output base. Several entries may steer to the same target. Two entries that swap their output bases over the two halves of the ID space invert the top bus bit. Separate entries let one ID reach several targets at once, each with its own translation.

A lookup is a one-cycle request. Raising `req_valid` for a cycle loads the response registers, and `rsp_valid` is high in the next cycle. A small two-state machine sequences this:
- **S_IDLE**: no response is presented.
- **S_RESP**: the registered response is presented.

Its transitions are:
- **IDLE→RESP**: a request arrives.
- **RESP→RESP**: a request arrives back to back.
- **RESP→IDLE**: no request arrives.
- **IDLE→IDLE**: the block stays idle.

Top module: `rid_msi_xlate`

## Requirements
- R1: After reset, `rsp_valid` and all `rsp_hit` bits are 0, every table entry is disabled, and the mask is 0xFFFF.
- R2: The mask is ANDed with the ID before any range test or subtraction. With mask 0x00FF only the device bits [7:3] and function bits [2:0] take part; bus bits [15:8] are ignored.
- R3: A masked ID m hits an entry when base <= m < base + length. The end is computed at 17 bits, so a window with base 0 and length 0x10000 includes 0xFFFF.
- R4: The sideband of a hit is (m - base + output base) mod 2^16. Target t's value sits in `rsp_sb[16*t+15:16*t]`.
- R5: A disabled entry never hits. An entry with length 0 never hits.
- R6: When several hitting entries name the same target, the entry with the lowest index supplies that target's value.
- R7: Targets are independent. One ID may hit several targets in the same response. A target with no hitting entry shows `rsp_hit[t]`=0 and sideband 0.
- R8: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid`=1, and 0 otherwise. While `rsp_valid` is 0, `rsp_hit` is 0.
- R9: A configuration write made in the same cycle as a request does not affect that request. It is seen by the next request.
- R10: Entry fields are written together with `cfg_ent_we` at index `cfg_ent_idx`. The target index `cfg_ent_tgt` selects bit t of `rsp_hit` and lane t of `rsp_sb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ent_we | input | 1 | Write one table entry |
| cfg_ent_idx | input | IDX_W | Entry index to write |
| cfg_ent_en | input | 1 | Entry enable |
| cfg_ent_base | input | 16 | First ID of the window |
| cfg_ent_len | input | 17 | Window length (0 to 0x10000) |
| cfg_ent_tgt | input | TGT_W | Target controller index |
| cfg_ent_obase | input | 16 | Sideband value produced for the first ID |
| cfg_mask_we | input | 1 | Write the global ID mask |
| cfg_mask | input | 16 | New mask value |
| req_valid | input | 1 | Lookup request pulse |
| req_rid | input | 16 | Requester ID to translate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | N_TGT | Per-target valid flags |
| rsp_sb | output | 16*N_TGT | Per-target sideband values, lane t at [16t+15:16t] |

## Verification
The table is loaded with several configurations and a broad spread of IDs is swept through each one.

| Configuration | What it separates |
|---|---|
| Identity map over the full 0x10000 window | Shows the 17-bit end handling and the unchanged sideband |
| Mask of 0x00FF | Shows the mask is applied before the range test, not after |
| Swapped-half inversion, with a second target mapped to identity | Shows per-target independence and the top-bit flip |
| Overlapping windows on one target, plus disabled and zero-length entries | Shows lowest-index priority and the exact half-open edges |

Two directed cases round this out. A write made in the same cycle as a request shows that an in-flight lookup never sees the new table. A lookup made straight after reset shows the default mask.

// File: rtl/rid_xlate_pkg.sv
package rid_xlate_pkg;
    localparam int RID_W = 16;

    typedef logic [RID_W-1:0] rid_t;
    typedef logic [RID_W:0]   rlen_t;

    typedef struct packed {
        logic  en;
        rid_t  base;
        rlen_t len;
        rid_t  obase;
    } xent_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } rsp_state_t;
endpackage

// File: rtl/rid_xlate_regs.sv
module rid_xlate_regs
    import rid_xlate_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int TGT_W = 2,
    parameter int IDX_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ent_we,
    input  logic [IDX_W-1:0]               ent_idx,
    input  xent_t                          ent_wdata,
    input  logic [TGT_W-1:0]               ent_tgt,
    input  logic                           mask_we,
    input  rid_t                           mask_wdata,
    output xent_t [N_ENT-1:0]              ents_o,
    output logic  [N_ENT-1:0][TGT_W-1:0]   tgts_o,
    output rid_t                           mask_o
);
    xent_t [N_ENT-1:0]            ents_q;
    logic  [N_ENT-1:0][TGT_W-1:0] tgts_q;
    rid_t                         mask_q;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents_q[e] <= '0;
                tgts_q[e] <= '0;
            end else if (ent_we && (ent_idx == IDX_W'(e))) begin
                ents_q[e] <= ent_wdata;
                tgts_q[e] <= ent_tgt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign ents_o = ents_q;
    assign tgts_o = tgts_q;
    assign mask_o = mask_q;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q)); // R9
endmodule

// File: rtl/rid_xlate_match.sv
module rid_xlate_match
    import rid_xlate_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  xent_t [N_ENT-1:0]            ents,
    input  rid_t                         mask,
    input  rid_t                         rid,
    output logic  [N_ENT-1:0]            hit_o,
    output rid_t  [N_ENT-1:0]            sb_o
);
    rid_t mrid;
    assign mrid = rid & mask;

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        rlen_t win_end;
        logic  lo_ok;
        logic  hi_ok;
        rid_t  offs;

        assign win_end  = {1'b0, ents[e].base} + ents[e].len;
        assign lo_ok    = (mrid >= ents[e].base);
        assign hi_ok    = ({1'b0, mrid} < win_end);
        assign offs     = mrid - ents[e].base;
        assign hit_o[e] = ents[e].en & lo_ok & hi_ok;
        assign sb_o[e]  = offs + ents[e].obase;

        always_comb begin
            if (hit_o[e] === 1'b1) begin
                AST_HIT_IN_WINDOW: assert ({1'b0, offs} < ents[e].len); // R3
                AST_HIT_NEEDS_EN: assert (ents[e].en && (ents[e].len != '0)); // R5
            end
        end
    end
endmodule

// File: rtl/rid_xlate_select.sv
module rid_xlate_select
    import rid_xlate_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int N_TGT = 4,
    parameter int TGT_W = 2
) (
    input  logic  [N_ENT-1:0]            ent_hit,
    input  rid_t  [N_ENT-1:0]            ent_sb,
    input  logic  [N_ENT-1:0][TGT_W-1:0] ent_tgt,
    output logic  [N_TGT-1:0]            tgt_hit,
    output rid_t  [N_TGT-1:0]            tgt_sb
);
    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        always_comb begin
            tgt_hit[t] = 1'b0;
            tgt_sb[t]  = '0;
            // Walk from highest to lowest so the lowest index wins last.
            for (int e = N_ENT - 1; e >= 0; e--) begin
                if (ent_hit[e] && (ent_tgt[e] == TGT_W'(t))) begin
                    tgt_hit[t] = 1'b1;
                    tgt_sb[t]  = ent_sb[e];
                end
            end
        end
    end
endmodule

// File: rtl/rid_msi_xlate.sv
module rid_msi_xlate
    import rid_xlate_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int N_TGT = 4,
    parameter int TGT_W = (N_TGT > 1) ? $clog2(N_TGT) : 1,
    parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_ent_we,
    input  logic [IDX_W-1:0]       cfg_ent_idx,
    input  logic                   cfg_ent_en,
    input  logic [15:0]            cfg_ent_base,
    input  logic [16:0]            cfg_ent_len,
    input  logic [TGT_W-1:0]       cfg_ent_tgt,
    input  logic [15:0]            cfg_ent_obase,
    input  logic                   cfg_mask_we,
    input  logic [15:0]            cfg_mask,
    input  logic                   req_valid,
    input  logic [15:0]            req_rid,
    output logic                   rsp_valid,
    output logic [N_TGT-1:0]       rsp_hit,
    output logic [16*N_TGT-1:0]    rsp_sb
);
    localparam int SB_W = RID_W * N_TGT;

    xent_t                        wr_ent;
    xent_t [N_ENT-1:0]            ents;
    logic  [N_ENT-1:0][TGT_W-1:0] tgts;
    rid_t                         mask;
    logic  [N_ENT-1:0]            ent_hit;
    rid_t  [N_ENT-1:0]            ent_sb;
    logic  [N_TGT-1:0]            tgt_hit;
    rid_t  [N_TGT-1:0]            tgt_sb;

    rsp_state_t           state_q, state_d;
    logic [N_TGT-1:0]     hit_q;
    logic [SB_W-1:0]      sb_q;

    assign wr_ent = '{en: cfg_ent_en, base: cfg_ent_base,
                      len: cfg_ent_len, obase: cfg_ent_obase};

    rid_xlate_regs #(.N_ENT(N_ENT), .TGT_W(TGT_W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_we     (cfg_ent_we),
        .ent_idx    (cfg_ent_idx),
        .ent_wdata  (wr_ent),
        .ent_tgt    (cfg_ent_tgt),
        .mask_we    (cfg_mask_we),
        .mask_wdata (cfg_mask),
        .ents_o     (ents),
        .tgts_o     (tgts),
        .mask_o     (mask)
    );

    rid_xlate_match #(.N_ENT(N_ENT)) u_match (
        .ents  (ents),
        .mask  (mask),
        .rid   (req_rid),
        .hit_o (ent_hit),
        .sb_o  (ent_sb)
    );

    rid_xlate_select #(.N_ENT(N_ENT), .N_TGT(N_TGT), .TGT_W(TGT_W)) u_sel (
        .ent_hit (ent_hit),
        .ent_sb  (ent_sb),
        .ent_tgt (tgts),
        .tgt_hit (tgt_hit),
        .tgt_sb  (tgt_sb)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_RESP;
            S_RESP: if (!req_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hit_q   <= '0;
            sb_q    <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                hit_q <= tgt_hit;
                sb_q  <= tgt_sb;
            end else begin
                hit_q <= '0;
                sb_q  <= '0;
            end
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            S_RESP: begin
                rsp_valid = 1'b1;
                rsp_hit   = hit_q;
                rsp_sb    = sb_q;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_hit   = '0;
                rsp_sb    = '0;
            end
        endcase
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8
    AST_NO_RSP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_hit == '0)); // R8
    AST_QUIET_IF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !$past(req_valid)) |=> $stable(rsp_sb)); // R8
endmodule

// File: tb/test_rid_msi_xlate.sv
module test_rid_msi_xlate;
    localparam int N_ENT = 8;
    localparam int N_TGT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ent_we = 1'b0;
    logic [2:0]  cfg_ent_idx = '0;
    logic        cfg_ent_en = 1'b0;
    logic [15:0] cfg_ent_base = '0;
    logic [16:0] cfg_ent_len = '0;
    logic [1:0]  cfg_ent_tgt = '0;
    logic [15:0] cfg_ent_obase = '0;
    logic        cfg_mask_we = 1'b0;
    logic [15:0] cfg_mask = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_rid = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_hit;
    logic [63:0] rsp_sb;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int m_en [N_ENT];
    int m_base [N_ENT];
    int m_len [N_ENT];
    int m_tgt [N_ENT];
    int m_ob [N_ENT];
    int m_mask;

    logic [3:0]  exp_hit;
    logic [63:0] exp_sb;

    always #5 clk = ~clk;

    rid_msi_xlate i_rid_msi_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_ent_we(cfg_ent_we), .cfg_ent_idx(cfg_ent_idx), .cfg_ent_en(cfg_ent_en),
        .cfg_ent_base(cfg_ent_base), .cfg_ent_len(cfg_ent_len), .cfg_ent_tgt(cfg_ent_tgt),
        .cfg_ent_obase(cfg_ent_obase), .cfg_mask_we(cfg_mask_we), .cfg_mask(cfg_mask),
        .req_valid(req_valid), .req_rid(req_rid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_sb(rsp_sb)
    );

    task automatic model_expect(input int id);
        int m;
        exp_hit = '0;
        exp_sb  = '0;
        m = id & m_mask;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (m_en[e] != 0 && m >= m_base[e] && m < m_base[e] + m_len[e]) begin
                exp_hit[m_tgt[e]] = 1'b1;
                exp_sb[16*m_tgt[e] +: 16] = 16'((m - m_base[e] + m_ob[e]) & 16'hFFFF);
            end
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ent(input int idx, input int en, input int base, input int len,
                          input int tgt, input int ob);
        @(negedge clk);
        cfg_ent_we = 1'b1; cfg_ent_idx = 3'(idx); cfg_ent_en = (en != 0);
        cfg_ent_base = 16'(base); cfg_ent_len = 17'(len);
        cfg_ent_tgt = 2'(tgt); cfg_ent_obase = 16'(ob);
        @(negedge clk);
        cfg_ent_we = 1'b0;
        m_en[idx] = en; m_base[idx] = base; m_len[idx] = len;
        m_tgt[idx] = tgt; m_ob[idx] = ob;
    endtask

    task automatic wr_mask(input int mask);
        @(negedge clk);
        cfg_mask_we = 1'b1; cfg_mask = 16'(mask);
        @(negedge clk);
        cfg_mask_we = 1'b0;
        m_mask = mask;
    endtask

    task automatic clear_all();
        for (int e = 0; e < N_ENT; e++) wr_ent(e, 0, 0, 0, 0, 0);
        wr_mask(16'hFFFF);
    endtask

    task automatic lookup(input int id, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_rid = 16'(id);
        model_expect(id);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {rsp_valid, 59'd0, rsp_hit}, {1'b1, 59'd0, exp_hit});
        n_checks--;
        check(req, rsp_sb, exp_sb);
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 1024; k++) lookup((k * 64 + (k % 64)) & 16'hFFFF, req);
    endtask

    initial begin
        for (int e = 0; e < N_ENT; e++) begin
            m_en[e] = 0; m_base[e] = 0; m_len[e] = 0; m_tgt[e] = 0; m_ob[e] = 0;
        end
        m_mask = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        check("R1 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 reset rsp_hit", {60'd0, rsp_hit}, 64'd0);
        rst_n = 1'b1;
        // R1: no entry is enabled after reset
        lookup(16'h1234, "R1 empty table");
        // R1: the default mask keeps every bit, so the bus byte still takes part
        wr_ent(0, 1, 16'hFF00, 16'h0100, 1, 16'h0040);
        lookup(16'hFFFF, "R1 default mask");
        lookup(16'h00FF, "R1 default mask miss");
        clear_all();

        // R3 R4 R10: identity map over the full window
        wr_ent(0, 1, 0, 17'h10000, 0, 0);
        lookup(16'hFFFF, "R3 top of 0x10000 window");
        lookup(16'h0000, "R3 bottom");
        sweep("R4 identity sweep");
        clear_all();

        // R2: mask 0x00FF removes the bus byte
        wr_mask(16'h00FF);
        wr_ent(0, 1, 0, 16'h0100, 1, 0);
        lookup(16'hAB35, "R2 mask keeps dev/fn");
        check("R2 lane1 value", {48'd0, rsp_sb[31:16]}, 64'h35);
        sweep("R2 masked sweep");
        clear_all();

        // R7: inversion of top bit on target 0, identity on target 2
        wr_ent(0, 1, 16'h0000, 16'h8000, 0, 16'h8000);
        wr_ent(1, 1, 16'h8000, 16'h8000, 0, 16'h0000);
        wr_ent(2, 1, 16'h0000, 17'h10000, 2, 16'h0000);
        lookup(16'h1234, "R7 dual target");
        check("R7 lane0 inverted", {48'd0, rsp_sb[15:0]}, 64'h9234);
        check("R7 lane2 identity", {48'd0, rsp_sb[47:32]}, 64'h1234);
        sweep("R7 inversion sweep");
        clear_all();

        // R5 R6: overlapping windows, disabled and zero-length entries
        wr_ent(3, 1, 16'h0100, 16'h0100, 1, 16'h5000);
        wr_ent(1, 1, 16'h0180, 16'h0100, 1, 16'h7000);
        wr_ent(5, 0, 16'h0000, 17'h10000, 3, 16'h1111);
        wr_ent(6, 1, 16'h0000, 16'h0000, 3, 16'h2222);
        wr_ent(7, 1, 16'hFFFF, 16'h0001, 2, 16'h0abc);
        lookup(16'h00FF, "R3 below base");
        lookup(16'h0100, "R3 at base");
        lookup(16'h017F, "R6 before overlap");
        lookup(16'h0180, "R6 overlap low index wins");
        check("R6 lane1", {48'd0, rsp_sb[31:16]}, 64'h7000);
        lookup(16'h01FF, "R6 overlap end");
        lookup(16'h0200, "R6 second window only");
        lookup(16'h027F, "R3 last in window");
        lookup(16'h0280, "R3 end excluded");
        lookup(16'hFFFF, "R3 single-id window at 0xFFFF");
        check("R5 target3 never hits", {63'd0, rsp_hit[3]}, 64'd0);
        sweep("R5 R6 priority sweep");

        // R9: a write in the same cycle as a request is not seen by it
        @(negedge clk);
        req_valid = 1'b1; req_rid = 16'h4000;
        model_expect(16'h4000);
        cfg_ent_we = 1'b1; cfg_ent_idx = 3'd0; cfg_ent_en = 1'b1;
        cfg_ent_base = 16'h4000; cfg_ent_len = 17'h10; cfg_ent_tgt = 2'd0;
        cfg_ent_obase = 16'h0077;
        @(negedge clk);
        req_valid = 1'b0; cfg_ent_we = 1'b0;
        check("R9 in-flight unaffected", {60'd0, rsp_hit}, {60'd0, exp_hit});
        m_en[0] = 1; m_base[0] = 16'h4000; m_len[0] = 16'h10; m_tgt[0] = 0; m_ob[0] = 16'h77;
        lookup(16'h4000, "R9 next lookup sees write");
        check("R9 new value", {48'd0, rsp_sb[15:0]}, 64'h77);

        // R8: no response in a cycle without a preceding request
        @(negedge clk);
        check("R8 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R8 idle rsp_hit", {60'd0, rsp_hit}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule